// File: doc/BRIEF.md
# Rational-Ratio Sine Oscillator

This block is a numerically controlled oscillator that feeds a 14-bit DAC. It keeps a phase counter that steps by a fixed increment on every enabled clock. The counter wraps at a modulus that need not be a power of two, so the tone frequency is the exact rational fraction STEP/MOD of the sample clock. No phase bits are dropped, so there is no truncation error. With the defaults (203/264), a 188.6 MHz sample clock gives a 145 MHz output. That tone lies above the first Nyquist zone, so the system uses the DAC image of the synthesized tone and not its fundamental.

Each phase state has its own entry in a sine table. The table is computed at elaboration, and a registered lookup turns the current phase into a signed sample. A strobe marks each new sample. The step and modulus are fixed by parameters. Nothing in the block changes the frequency at run time.

Top module: `nco_ratio_top`

## Requirements
- R1: On each rising clock edge with `en` high, the phase advances by STEP (203) modulo MOD (264). The n-th valid sample after reset (n = 0, 1, …) therefore equals table entry (203·n) mod 264.
- R2: The phase always stays in the range 0 to MOD−1 (0..263). It wraps by subtracting MOD whenever the sum reaches or exceeds MOD.
- R3: Table entry k is round(8191·sin(2π·k/264)), with ties rounded away from zero. `sample` is 14-bit two's complement and its magnitude never exceeds 8191.
- R4: While `rst_n` is low at a rising edge, the reset is synchronous and sets the phase to 0, `sample` to 0 and `sample_vld` to 0. The first valid sample after reset is entry 0, which has the value 0.
- R5: `sample_vld` is high in exactly the cycles after an edge at which `en` was high. The sample taken from the phase held at that edge appears after one register stage.
- R6: An edge with `en` low leaves the phase unchanged and clears `sample_vld`. It also keeps `sample` at its previous value, so the sequence resumes where it stopped.
- R7: Over consecutive valid samples, the output sequence repeats every 264 samples and has no shorter period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance phase and produce a sample on this edge |
| sample | output | 14 | Signed sine sample for the DAC |
| sample_vld | output | 1 | High for one cycle per new sample |

## Verification
The bench focuses on the points where the wrap at 264 happens. A power-of-two wrap, or a wrap at "greater than" instead of "greater or equal", would send the sequence off the reference table within a few samples. Random gaps in `en` check that a stalled cycle freezes the phase. A design that kept advancing would skip table entries, and one that cleared the sample would put zeros into the DAC stream. A reset taken in the middle of a run must make the next sample entry 0; a design that reset late would emit entry 203 first. A full period of 264 samples is captured and compared with its successor and with every shorter shift, which catches a wrong step or modulus that happens to stay in range.

// File: rtl/nco_ratio_pkg.sv
// Package: nco_ratio_pkg
// Shared helpers for the rational-ratio oscillator. The sine table is
// computed here at elaboration time, so no table is written out by hand.
// Assumes the amplitude fits the signed output width chosen by the user.
package nco_ratio_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded sine value for phase state k of a modulus-mod circle.
    function automatic int sine_entry(input int k, input int mod, input int amp);
        real x;
        x = real'(amp) * $sin(TWO_PI * real'(k) / real'(mod));
        return int'(x);
    endfunction

endpackage

// File: rtl/nco_phase_wrap.sv
// Module: nco_phase_wrap
// Phase counter that steps by STEP on each enabled clock and wraps at MOD,
// where MOD may be any integer. Assumes 0 < STEP < MOD.
// Reset is synchronous and active low and clears the phase to 0.
module nco_phase_wrap #(
    parameter int STEP = 203,
    parameter int MOD  = 264,
    localparam int PH_W = $clog2(MOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic [PH_W-1:0] phase
);

    localparam int SUM_W = PH_W + 1;

    logic [SUM_W-1:0] sum;
    logic [PH_W-1:0]  phase_next;

    // Raw sum, then a single conditional subtract folds it back into range.
    always_comb begin
        sum = {1'b0, phase} + SUM_W'(STEP);
        if (sum >= SUM_W'(MOD)) begin
            phase_next = PH_W'(sum - SUM_W'(MOD));
        end else begin
            phase_next = PH_W'(sum);
        end
    end

    // Phase register: cleared by reset, held when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            phase <= phase_next;
        end
    end

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < MOD);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |->
            ((int'(phase) + MOD - int'($past(phase))) % MOD) == STEP);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> phase == $past(phase));

endmodule

// File: rtl/nco_sine_lut.sv
// Module: nco_sine_lut
// Registered sine lookup with one entry for each phase state. Entries are
// computed at elaboration. A new sample is loaded only when load is high;
// otherwise the last sample is kept. Assumes AMP < 2**(OUT_W-1).
module nco_sine_lut #(
    parameter int MOD   = 264,
    parameter int OUT_W = 14,
    parameter int AMP   = 8191,
    localparam int PH_W = $clog2(MOD)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PH_W-1:0]         phase,
    output logic signed [OUT_W-1:0] sample
);

    logic signed [OUT_W-1:0] table_q [MOD];

    // One constant entry per phase state.
    for (genvar k = 0; k < MOD; k++) begin : g_entry
        localparam int VAL = nco_ratio_pkg::sine_entry(k, MOD, AMP);
        assign table_q[k] = OUT_W'(VAL);
    end

    // Output register: zero on reset, updated only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else if (load) begin
            sample <= table_q[phase];
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sample) <= AMP) && (int'(sample) >= -AMP));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> sample == $past(sample));

endmodule

// File: rtl/nco_ratio_top.sv
// Module: nco_ratio_top
// Rational-ratio NCO: a modulus-MOD phase counter drives a registered sine
// table. The output tone is exactly STEP/MOD of the clock. Reset is
// synchronous and active low. The sample for the phase held at an enabled
// edge appears one register later, flagged by sample_vld.
module nco_ratio_top #(
    parameter int STEP  = 203,
    parameter int MOD   = 264,
    parameter int OUT_W = 14,
    parameter int AMP   = 8191
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    output logic signed [OUT_W-1:0] sample,
    output logic                    sample_vld
);

    localparam int PH_W = $clog2(MOD);

    logic [PH_W-1:0] phase;

    nco_phase_wrap #(
        .STEP (STEP),
        .MOD  (MOD)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .phase (phase)
    );

    nco_sine_lut #(
        .MOD   (MOD),
        .OUT_W (OUT_W),
        .AMP   (AMP)
    ) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (en),
        .phase  (phase),
        .sample (sample)
    );

    // Valid strobe: marks the cycle after each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= en;
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sample_vld == $past(en));

    p_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sample_vld && sample == '0));

endmodule

// File: tb/tb_nco_ratio_top.sv
module tb_nco_ratio_top;

    localparam int STEP = 203;
    localparam int MOD  = 264;
    localparam int AMP  = 8191;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic signed [13:0] sample;
    logic sample_vld;

    int n_checks = 0;
    int n_fail = 0;
    int n_valid = 0;
    logic en_prev = 1'b0;
    logic signed [13:0] last_sample = '0;
    int capt [2*MOD];
    int n_capt = 0;
    bit capturing = 1'b0;

    always #2.5 clk = ~clk;

    nco_ratio_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    function automatic int ref_entry(input int k);
        real v;
        v = real'(AMP) * $sin(2.0 * 3.141592653589793 * real'(k) / real'(MOD));
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge: checks outputs from the last rising edge,
    // then drives en for the next one.
    task automatic step(input logic new_en);
        @(negedge clk);
        check(sample_vld == en_prev, "R5 valid latency", int'(sample_vld), int'(en_prev));
        if (en_prev) begin
            check(int'(sample) == ref_entry((STEP * n_valid) % MOD),
                  "R1 sequence", int'(sample), ref_entry((STEP * n_valid) % MOD));
            check(int'(sample) <= AMP && int'(sample) >= -AMP, "R3 range", int'(sample), AMP);
            if (capturing && n_capt < 2*MOD) begin
                capt[n_capt] = int'(sample);
                n_capt++;
            end
            n_valid++;
        end else begin
            check(sample == last_sample, "R6 hold", int'(sample), int'(last_sample));
        end
        last_sample = sample;
        en = new_en;
        en_prev = new_en;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        repeat (4) @(negedge clk);
        check(sample_vld == 1'b0, "R4 reset valid", int'(sample_vld), 0);
        check(sample == '0, "R4 reset sample", int'(sample), 0);
        rst_n = 1'b1;
        en = 1'b0;
        en_prev = 1'b0;
        n_valid = 0;
        last_sample = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20160426));
        do_reset();
        // R4: first enabled edge yields entry 0, next entry 203.
        step(1'b1);
        step(1'b1);
        check(int'(sample) == 0, "R4 first sample", int'(sample), 0);
        step(1'b1);
        check(int'(sample) == ref_entry(203), "R1 second sample", int'(sample), ref_entry(203));
        // R3: spot table values through the ordinary sequence.
        check(ref_entry(66) == 8191 && ref_entry(198) == -8191, "R3 ref peaks",
              ref_entry(66), 8191);
        // Random enable gaps (R6) across many wraps (R2).
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0);
        end
        // Directed: long stall then resume.
        for (int i = 0; i < 20; i++) step(1'b0);
        for (int i = 0; i < 10; i++) step(1'b1);
        // Mid-run reset (R4).
        do_reset();
        step(1'b1);
        step(1'b1);
        check(int'(sample) == 0, "R4 first after mid-run reset", int'(sample), 0);
        // Capture two periods with continuous enable (R7).
        capturing = 1'b1;
        for (int i = 0; i < 2*MOD + 4; i++) step(1'b1);
        capturing = 1'b0;
        step(1'b0);
        check(n_capt == 2*MOD, "R7 capture count", n_capt, 2*MOD);
        for (int i = 0; i < MOD; i++) begin
            check(capt[i] == capt[i+MOD], "R7 period 264", capt[i+MOD], capt[i]);
        end
        for (int d = 1; d < MOD; d++) begin
            bit differs = 1'b0;
            for (int i = 0; i < MOD; i++) begin
                if (capt[i] != capt[i+d]) differs = 1'b1;
            end
            check(differs, "R7 no shorter period", d, MOD);
        end
        // R2: every phase state visited once per period -> sum near zero.
        begin
            int s = 0;
            for (int i = 0; i < MOD; i++) s += capt[i];
            check(s > -MOD && s < MOD, "R2 full phase coverage", s, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule